// File: doc/BRIEF.md
# Double-Buffered Split-Byte Converter Code Register

This block is the digital front end of a 12-bit voltage-output converter. A host writes a code over a 12-bit parallel bus using active-low strobes. A write strobe and two part selects steer the bus into two input registers. One holds the low eight bits and the other holds the upper four. A separate active-low load strobe moves the assembled word into a 12-bit converter register, and that register drives the converter. An active-low clear and the block's reset both return every register to zero.

The strobes arrive asynchronously, and the block samples them on a fast system clock. Every strobe and data pin passes through the same two-flop synchronizer. A pin change therefore reaches the logic with the same delay on every line. The level-sensitive "transparent while low, hold on the rising edge" behaviour of both register stages is then modelled in this one clock domain. Holding the write, both selects and load low at once chains the two stages, so the bus flows straight through to the converter code. The code and a one-cycle change pulse are registered outputs.

Top module: `dac_front`

## Requirements
- R1: While write and low select are both low, the low input register (code bits 7:0) follows bus bits 7:0. It holds its value once either strobe returns high. A high-nibble-only write leaves it unchanged.
- R2: While write and high select are both low, the high input register (code bits 11:8) follows bus bits 11:8. It holds its value once either strobe returns high. A low-byte-only write leaves it unchanged.
- R3: With write and both selects low, all twelve bus bits enter the input registers together. A rise of write alone then captures both registers.
- R4: While load is low, the converter code follows the high register concatenated above the low register. While load is high, the code is held and input-register writes or bus changes do not alter it.
- R5: With write, both selects and load all low, the bus passes through both stages to the converter code.
- R6: While clear is low, both input registers and the code are zero, whatever the other strobes do. After clear is released, the input registers still read zero.
- R7: An active-high synchronous reset zeroes both input registers and the code, and holds the change pulse low.
- R8: A pin change appears at the code output on the third rising clock edge after it, and not earlier.
- R9: When a select and write rise in the same sample as the bus changes, the register keeps the bus value from the sample before.
- R10: The change pulse is high for exactly one cycle each time the code changes, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset (power-on clear) |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| sel_lo_n | input | 1 | Low-byte select, active low, asynchronous |
| sel_hi_n | input | 1 | High-nibble select, active low, asynchronous |
| load_n | input | 1 | Converter register load, active low, asynchronous |
| clear_n | input | 1 | Clear of all registers, active low, asynchronous |
| data_in | input | 12 | Parallel code bus |
| code | output | 12 | Registered converter code |
| code_upd | output | 1 | One-cycle pulse when the code changed |

## Verification
Pins travel through two synchronizer flops and then through the converter register. A pin change therefore reaches `code` and `code_upd` on the third rising edge. The bench holds each stimulus for six edges before it compares the result. This leaves every result settled, however the strobes and the bus were combined. For the latency case the bench samples between edges two and three, where the old code must still show. It samples again after edge three, where the new code must be present. Pulses are counted over the whole hold window, so a missing pulse or an extra pulse is detected as well as a wrong code.

// File: rtl/dac_front_pkg.sv
`timescale 1ns/1ps
package dac_front_pkg;

  // Internal, active-high view of the five strobe pins
  typedef struct packed {
    logic clr;
    logic ld;
    logic sel_hi;
    logic sel_lo;
    logic wr;
  } strobe_t;

  localparam int unsigned STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/dac_front_sync.sv
`timescale 1ns/1ps
module dac_front_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dac_front_stage.sv
`timescale 1ns/1ps
module dac_front_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             open_i,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_nxt
);

  // Clear dominates, an open stage follows d, a closed stage holds
  always_comb begin
    if (clr)         q_nxt = '0;
    else if (open_i) q_nxt = d;
    else             q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  // A closed stage keeps its contents (also guards R1 and R2)
  assert_closed_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!open_i && !clr) |=> $stable(q));

  // On closing, the stage shows the input from the sample before
  assert_capture_prev_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(open_i) && !clr && !$past(clr)) |-> (q == $past(d)));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

endmodule

// File: rtl/dac_front.sv
`timescale 1ns/1ps
module dac_front #(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned LO_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi_n,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic [CODE_W-1:0] data_in,
  output logic [CODE_W-1:0] code,
  output logic              code_upd
);
  import dac_front_pkg::*;

  localparam int unsigned HI_W = CODE_W - LO_W;

  logic [STROBE_W-1:0] pins_n, pins_s;
  logic [CODE_W-1:0]   data_s;
  strobe_t             act;
  logic                open_lo, open_hi;
  logic [LO_W-1:0]     lo_q, lo_nxt;
  logic [HI_W-1:0]     hi_q, hi_nxt;
  logic [CODE_W-1:0]   dac_nxt;

  assign pins_n = {clear_n, load_n, sel_hi_n, sel_lo_n, wr_n};

  // Strobes and bus share one synchronizer depth so they stay aligned
  dac_front_sync #(
    .WIDTH(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL({STROBE_W{1'b1}})
  ) u_sync_strobe (
    .clk(clk), .rst(rst), .d(pins_n), .q(pins_s)
  );

  dac_front_sync #(
    .WIDTH(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)
  ) u_sync_data (
    .clk(clk), .rst(rst), .d(data_in), .q(data_s)
  );

  assign act     = strobe_t'(~pins_s);
  assign open_lo = act.wr & act.sel_lo;
  assign open_hi = act.wr & act.sel_hi;

  dac_front_stage #(.WIDTH(LO_W)) u_in_lo (
    .clk(clk), .rst(rst), .clr(act.clr), .open_i(open_lo),
    .d(data_s[LO_W-1:0]), .q(lo_q), .q_nxt(lo_nxt)
  );

  dac_front_stage #(.WIDTH(HI_W)) u_in_hi (
    .clk(clk), .rst(rst), .clr(act.clr), .open_i(open_hi),
    .d(data_s[CODE_W-1:LO_W]), .q(hi_q), .q_nxt(hi_nxt)
  );

  // Second stage takes the next input-register values: chained transparency
  dac_front_stage #(.WIDTH(CODE_W)) u_dac (
    .clk(clk), .rst(rst), .clr(act.clr), .open_i(act.ld),
    .d({hi_nxt, lo_nxt}), .q(code), .q_nxt(dac_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) code_upd <= 1'b0;
    else     code_upd <= (dac_nxt != code);
  end

  assert_lo_isolated_R1: assert property (@(posedge clk) disable iff (rst)
    (open_hi && !open_lo && !act.clr) |=> $stable(lo_q));

  assert_hi_isolated_R2: assert property (@(posedge clk) disable iff (rst)
    (open_lo && !open_hi && !act.clr) |=> $stable(hi_q));

  assert_both_load_R3: assert property (@(posedge clk) disable iff (rst)
    (open_lo && open_hi && !act.clr) |=> ({hi_q, lo_q} == $past(data_s)));

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (rst)
    (open_lo && open_hi && act.ld && !act.clr) |=> (code == $past(data_s)));

  assert_reset_zero_R7: assert property (@(posedge clk)
    rst |=> (code == '0 && !code_upd));

  assert_pulse_on_change_R10: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |-> code_upd);

  assert_pulse_only_change_R10: assert property (@(posedge clk) disable iff (rst)
    code_upd |-> (code != $past(code)));

endmodule

// File: tb/dac_front_bench.sv
`timescale 1ns/1ps
module dac_front_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_n = 1'b1, sel_lo_n = 1'b1, sel_hi_n = 1'b1;
  logic        load_n = 1'b1, clear_n = 1'b1;
  logic [11:0] data_in = '0;
  logic [11:0] code;
  logic        code_upd;

  always #2.5 clk = ~clk;

  dac_front u_dac_front (
    .clk(clk), .rst(rst), .wr_n(wr_n), .sel_lo_n(sel_lo_n),
    .sel_hi_n(sel_hi_n), .load_n(load_n), .clear_n(clear_n),
    .data_in(data_in), .code(code), .code_upd(code_upd)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int pulses = 0;

  // Expected state built from the requirements
  logic [7:0]  e_lo = '0;
  logic [3:0]  e_hi = '0;
  logic [11:0] e_code = '0;

  // Scoreboard queues
  logic [11:0] sb_code[$];
  int          sb_puls[$];
  string       sb_tag[$];

  logic [11:0] m_code;
  int          m_puls;
  string       m_tag;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (code_upd === 1'b1) pulses++;

  // Monitor: compare each expected item once it is due
  always @(negedge clk) begin
    if (sb_code.size() != 0) begin
      m_code = sb_code.pop_front();
      m_puls = sb_puls.pop_front();
      m_tag  = sb_tag.pop_front();
      check(m_tag, int'(code), int'(m_code));
      check({"R10 pulses, ", m_tag}, pulses, m_puls);
    end
  end

  // Driver: apply pins, update the expected state, push the result
  task automatic step(input logic w, sl, sh, l, c, input logic [11:0] d,
                      input bit lat, input string tag);
    logic [11:0] old;
    @(posedge clk); #1;
    pulses = 0;
    old = e_code;
    wr_n = w; sel_lo_n = sl; sel_hi_n = sh; load_n = l; clear_n = c;
    data_in = d;
    if (!c) begin
      e_lo = '0; e_hi = '0; e_code = '0;
    end else begin
      if (!w && !sl) e_lo = d[7:0];
      if (!w && !sh) e_hi = d[11:8];
      if (!l)        e_code = {e_hi, e_lo};
    end
    if (lat) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R8 old code after two edges", int'(code), int'(old));
      @(posedge clk); @(negedge clk);
      check("R8 new code after third edge", int'(code), int'(e_code));
      repeat (3) @(posedge clk);
    end else begin
      repeat (6) @(posedge clk);
    end
    #1;
    sb_code.push_back(e_code);
    sb_puls.push_back((e_code != old) ? 1 : 0);
    sb_tag.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(posedge clk); #1;
    pulses = 0;
    wr_n = 1; sel_lo_n = 1; sel_hi_n = 1; load_n = 1; clear_n = 1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    e_lo = '0; e_hi = '0; e_code = '0;
    repeat (4) @(posedge clk);
    #1;
    sb_code.push_back(12'h000);
    sb_puls.push_back(0);
    sb_tag.push_back(tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R7 code zero after reset", int'(code), 0);
    check("R7 pulse low after reset", int'(code_upd), 0);

    step(0,0,1,1,1, 12'hABC, 0, "R1 low byte open, load closed");
    step(1,0,1,1,1, 12'hABC, 0, "R1 capture on write rise");
    step(1,1,1,0,1, 12'h000, 0, "R4 load open shows low byte");
    step(1,1,1,1,1, 12'h123, 0, "R4 load closed holds code");
    step(0,1,0,1,1, 12'h5FF, 0, "R2 high nibble open, R4 load closed");
    step(0,1,1,1,1, 12'h5FF, 0, "R2 capture on select rise");
    step(1,1,1,1,1, 12'h5FF, 0, "R2 idle");
    step(1,1,1,0,1, 12'h777, 0, "R1 R2 low byte kept by nibble write");
    step(0,0,0,1,1, 12'h3A7, 0, "R3 both selects open, load high");
    step(1,0,0,1,1, 12'h3A7, 0, "R3 write rise captures both");
    step(1,0,0,1,1, 12'hFFF, 0, "R3 held after write rise");
    step(1,1,1,0,1, 12'hFFF, 0, "R4 load shows 12-bit word");
    step(1,1,1,0,1, 12'h000, 0, "R4 bus change with write high");
    step(0,0,0,0,1, 12'h9E1, 0, "R5 pass-through");
    step(0,0,0,0,1, 12'h246, 1, "R5 R8 pass-through latency");
    step(0,0,0,0,0, 12'hFFF, 0, "R6 clear overrides pass-through");
    step(1,1,1,1,0, 12'hFFF, 0, "R6 clear held");
    step(1,1,1,1,1, 12'hFFF, 0, "R6 clear released");
    step(1,1,1,0,1, 12'hFFF, 0, "R6 input registers cleared");
    step(1,1,1,1,1, 12'hFFF, 0, "R6 idle");
    step(0,0,1,1,1, 12'h0C3, 0, "R9 low byte open");
    step(1,1,1,1,1, 12'h03C, 0, "R9 rise with new bus value");
    step(1,1,1,0,1, 12'h03C, 0, "R9 previous bus value captured");
    step(1,1,1,1,1, 12'h03C, 0, "R9 idle");
    step(0,0,1,0,1, 12'h0AA, 1, "R8 latency through write and load");
    do_reset("R7 mid-run reset");
    step(1,1,1,0,1, 12'h0AA, 0, "R7 registers zero after reset");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule